// File: doc/BRIEF.md
# Multiplexed Bus Read Cycle Sequencer

The sequencer runs one read cycle on an external bus that shares sixteen lines between the address and the data. One clock of the block is one quarter of an instruction cycle, so four clocks make one phase period Q1..Q4. A request gives a byte address and says whether the cycle is an instruction fetch or a single-byte table read. The sequencer first drives the word address with a latch strobe and then releases the shared lines. It pulls the output enable low and captures the 16-bit word as the enable returns high. A fetch hands back the whole word. A table read hands back the one byte that the address LSb selects.

Requests come in on a valid/ready channel. `req_ready` is high only when no cycle is running and no response is waiting. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Responses leave on a valid/ready channel. Once `rsp_valid` rises, it and `rsp_data` hold until `rsp_ready` is sampled high. No new request is taken while a response is held. The wait setting `wait_sel`/`wait_off` is sampled when the request is taken.

Top module: `bus_read_seq`

## Requirements
- R1: In the first clock after a request is taken (Q1), `ale`=1, `ad_oe`=1, `ad_out` = address bits [16:1] and `a_hi` = address bits [20:17]. `ale` is high for that single clock only. In Q2, `ale`=0 and the word address is still driven, so an external latch that captures on the falling edge of `ale` holds the word address.
- R2: `oe_n` goes low in the first Q3 and stays low through the final Q4. `ad_oe` is 0 from Q3 until the cycle ends.
- R3: `ba0` equals the address LSb during the first Q3 only, and is 0 at all other times.
- R4: `a_hi` holds address bits [20:17] and `ce_n` is 0 from Q1 through the final Q4. Together with the latched `ad_out` this gives the external word address A[19:0] = byte address [20:1].
- R5: The word on `ad_in` is sampled at the clock edge that ends the final Q4. A fetch returns the whole word. A table read returns {8'h00, ad_in[7:0]} when the address LSb is 0 and {8'h00, ad_in[15:8]} when it is 1.
- R6: A table read adds N extra phase periods with `oe_n` held low. N is 3 − `wait_sel` (11→0, 10→1, 01→2, 00→3), and N is 0 when `wait_off`=1. The cycle therefore lasts 4·(1+N) clocks.
- R7: A fetch never adds wait periods, whatever the wait setting. It always lasts 4 clocks.
- R8: `rsp_valid` rises in the clock after the final Q4. While `rsp_ready` is 0, `rsp_valid` and `rsp_data` hold. `req_ready` is high only when the block is idle and holds no response.
- R9: When idle: `ale`=0, `oe_n`=1, `ce_n`=1, `ba0`=0, `ad_oe`=0, `a_hi`=0.
- R10: After reset the block is idle (R9), with `req_ready`=1 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-instruction-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 21 | Byte address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = table read |
| wait_sel | input | 2 | Table wait setting (inverted encoding) |
| wait_off | input | 1 | 1 forces zero wait periods |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 16 | Word (fetch) or zero-extended byte (table read) |
| ad_out | output | 16 | Shared-line drive value |
| ad_oe | output | 1 | Shared-line drive enable |
| ad_in | input | 16 | Shared-line sampled value |
| a_hi | output | 4 | Upper word-address lines |
| ale | output | 1 | Address latch strobe, active high |
| oe_n | output | 1 | Output enable, active low |
| ba0 | output | 1 | Byte-address LSb strobe |
| ce_n | output | 1 | Chip enable, active low |

## Verification
Every wait setting is run both as a table read and as a fetch. This catches a reversed wait encoding, which would stretch the wrong cycles, and a fetch that wrongly takes wait periods, which would finish late. Table reads at odd and even addresses, including the all-ones and all-zero addresses, expose a swapped byte select or an address shifted by one bit. The shift would show up as the wrong word coming back through the latch. The response consumer stalls at irregular intervals. A design that drops or changes a held response, or takes a new request too early, then diverges from the clock-by-clock model. Wait periods also check that `ale` and `ba0` are not pulsed again.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [1:0] {PH_Q1, PH_Q2, PH_Q3, PH_Q4} qphase_e;

  // Wait periods from the inverted setting; fetches and the disable give zero.
  function automatic logic [1:0] wait_periods(input logic [1:0] sel,
                                              input logic off,
                                              input logic fetch);
    return (off || fetch) ? 2'd0 : ~sel;
  endfunction
endpackage

// File: rtl/bus_seq_timer.sv
module bus_seq_timer #(
  parameter int WCNT_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [WCNT_W-1:0]    wait_n,
  output logic                 active,
  output bus_seq_pkg::qphase_e phase,
  output logic                 first,
  output logic                 last
);
  import bus_seq_pkg::*;
  logic [WCNT_W-1:0] wcnt;

  assign last = active && (phase == PH_Q4) && (wcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= PH_Q1;
      wcnt   <= '0;
      first  <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      phase  <= PH_Q1;
      wcnt   <= wait_n;
      first  <= 1'b1;
    end else if (active) begin
      phase <= qphase_e'(phase + 2'd1);
      if (phase == PH_Q4) begin
        first <= 1'b0;
        if (wcnt == '0) active <= 1'b0;
        else            wcnt   <= wcnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_seq_capture.sv
module bus_seq_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              fetch,
  input  logic              lsb,
  input  logic [DATA_W-1:0] word,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int BYTE_W = DATA_W / 2;
  logic [DATA_W-1:0] picked;

  always_comb begin
    if (fetch)    picked = word;
    else if (lsb) picked = {{BYTE_W{1'b0}}, word[DATA_W-1:BYTE_W]};
    else          picked = {{BYTE_W{1'b0}}, word[BYTE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (cap) begin
      rsp_valid <= 1'b1;
      rsp_data  <= picked;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_read_seq.sv
module bus_read_seq #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_fetch,
  input  logic [WAIT_W-1:0]        wait_sel,
  input  logic                     wait_off,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [DATA_W-1:0]        rsp_data,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-2:0] a_hi,
  output logic                     ale,
  output logic                     oe_n,
  output logic                     ba0,
  output logic                     ce_n
);
  import bus_seq_pkg::*;
  localparam int HI_W = ADDR_W - DATA_W - 1;

  logic [ADDR_W-1:0] addr_q;
  logic              fetch_q;
  logic              start, active, first, last;
  qphase_e           phase;
  logic              addr_phase;

  assign req_ready = !active && !rsp_valid;
  assign start     = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      fetch_q <= 1'b0;
    end else if (start) begin
      addr_q  <= req_addr;
      fetch_q <= req_fetch;
    end
  end

  bus_seq_timer #(.WCNT_W(WAIT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .wait_n (wait_periods(wait_sel, wait_off, req_fetch)),
    .active (active),
    .phase  (phase),
    .first  (first),
    .last   (last)
  );

  bus_seq_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (last),
    .fetch     (fetch_q),
    .lsb       (addr_q[0]),
    .word      (ad_in),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign addr_phase = active && first && (phase == PH_Q1 || phase == PH_Q2);
  assign ad_oe  = addr_phase;
  assign ad_out = addr_phase ? addr_q[DATA_W:1] : '0;
  assign ale    = active && first && (phase == PH_Q1);
  assign oe_n   = !(active && (!first || phase == PH_Q3 || phase == PH_Q4));
  assign ba0    = active && first && (phase == PH_Q3) && addr_q[0];
  assign ce_n   = !active;
  assign a_hi   = active ? addr_q[ADDR_W-1 -: HI_W] : '0;
endmodule

// File: rtl/bus_read_seq_checker.sv
module bus_read_seq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_data,
  input logic        ad_oe,
  input logic        ale,
  input logic        oe_n,
  input logic        ba0,
  input logic        ce_n
);
  a_r1_ale_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ale);
  a_r1_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale && ad_oe);
  a_r2_no_drive_fight: assert property (@(posedge clk) disable iff (!rst_n)
    !(ad_oe && !oe_n));
  a_r3_ba0_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    ba0 |-> !oe_n);
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ce_n && oe_n && !ale);
endmodule

bind bus_read_seq bus_read_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .ad_oe(ad_oe), .ale(ale), .oe_n(oe_n), .ba0(ba0), .ce_n(ce_n)
);

// File: tb/tb_bus_read_seq.sv
`timescale 1ns/1ps
module tb_bus_read_seq;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_fetch = 0, wait_off = 0, rsp_ready = 1;
  logic [20:0] req_addr = '0;
  logic [1:0]  wait_sel = 2'b11;
  logic        req_ready, rsp_valid, ad_oe, ale, oe_n, ba0, ce_n;
  logic [15:0] rsp_data, ad_out, ad_in;
  logic [3:0]  a_hi;
  logic [15:0] lat = '0;

  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  bus_read_seq dut (.*);

  function automatic logic [15:0] memf(input logic [19:0] w);
    return 16'(w[15:0] * 16'd40503) ^ {4'h0, w[19:8]};
  endfunction

  // External address latch and memory.
  always @(negedge ale) lat <= ad_out;
  assign ad_in = !oe_n ? memf({a_hi, lat}) : 16'hA5A5;

  // Behavioural reference: t = clocks since cycle start, -1 when idle.
  int          t = -1, len = 0;
  logic [20:0] m_addr = '0;
  logic        m_fetch = 0, m_rv = 0;
  logic [15:0] m_rd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      t <= -1; m_rv <= 0;
    end else begin
      if (t >= 0) begin
        if (t == len - 1) begin
          logic [15:0] w;
          w = memf(m_addr[20:1]);
          t <= -1; m_rv <= 1;
          m_rd <= m_fetch ? w : (m_addr[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]});
        end else t <= t + 1;
      end
      if (m_rv && rsp_ready) m_rv <= 0;
      if (req_valid && t < 0 && !m_rv) begin
        int n;
        n = (req_fetch || wait_off) ? 0 : 3 - int'(wait_sel);
        t <= 0; len <= 4 * (1 + n); m_addr <= req_addr; m_fetch <= req_fetch;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cyc=%0d act=%h exp=%h", tag, cyc, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    rsp_ready <= (cyc % 5) != 0 && (cyc % 7) != 3;
    if (rst_n) begin
      chk(t < 0 ? "R9 idle ale" : "R1 ale", 32'(ale), 32'(t == 0));
      chk("R1 ad_oe", 32'(ad_oe), 32'(t == 0 || t == 1));
      if (t == 0 || t == 1) chk("R1 ad_out", 32'(ad_out), 32'(m_addr[16:1]));
      chk(t >= 4 ? "R6 oe_n wait" : "R2 oe_n", 32'(oe_n), 32'(!(t >= 2)));
      chk("R3 ba0", 32'(ba0), 32'(t == 2 && m_addr[0]));
      chk("R4 ce_n", 32'(ce_n), 32'(t < 0));
      chk("R4 a_hi", 32'(a_hi), t >= 0 ? 32'(m_addr[20:17]) : 32'd0);
      chk("R8 req_ready", 32'(req_ready), 32'(t < 0 && !m_rv));
      chk(m_fetch ? "R7 rsp_valid" : "R6 rsp_valid", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) chk("R5 rsp_data", 32'(rsp_data), 32'(m_rd));
    end
  end

  task automatic send(input logic [20:0] a, input logic f,
                      input logic [1:0] s, input logic off);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = a; req_fetch = f; wait_sel = s; wait_off = off;
    @(negedge clk);
    req_valid = 0; wait_sel = ~s;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 req_ready", 32'(req_ready), 32'd1);
    chk("R10 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R10 idle pins", {27'd0, ale, oe_n, ce_n, ba0, ad_oe}, {27'd0, 5'b01100});
    rst_n = 1;
    send(21'h000000, 1, 2'b00, 0);   // R7 fetch ignores wait
    send(21'h1FFFFF, 1, 2'b11, 0);
    send(21'h12345, 0, 2'b11, 0);    // odd, 0 waits
    send(21'h12346, 0, 2'b10, 0);    // even, 1 wait
    send(21'h0ABCD, 0, 2'b01, 0);    // 2 waits
    send(21'h1FFFFF, 0, 2'b00, 0);   // 3 waits, top address
    send(21'h000000, 0, 2'b00, 0);   // 3 waits, address zero
    send(21'h155555, 0, 2'b00, 1);   // disable forces 0
    send(21'h0AAAAA, 1, 2'b10, 0);
    for (int i = 0; i < 40; i++)
      send(21'(i * 21'h0B3A7 + 5), i[0], 2'(i >> 1), i[3] & i[2]);
    repeat (40) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule